// File: doc/BRIEF.md
# Host Port Control Register with Init Sequencer

This block is the control side of an 8-bit parallel host port. The host reads and writes one control byte. That byte holds the receive and transmit request enables, two general-purpose host flags, a two-bit transfer mode and a one-shot init command. The mode picks either interrupt-driven transfer or DMA packing of 24, 16 or 8 bits per word. The data-path logic next to this block reads the mode, the host flags, four transfer flags and a 2-bit byte address counter.

When the host writes the control byte with the init bit set, the block runs the init command on the next clock edge and then clears the bit. Init sets or clears a group of transfer flags, and the request enables choose which group. Init also reloads the byte counter. In interrupt mode the counter is reloaded with zero. In a DMA mode it is reloaded with the mode value. A DMA mode with both request enables set is illegal. The block reports this combination and leaves the flags alone. Between init commands the data path moves the flags with set and clear strobes and steps the counter once per byte.

Top module: `hport_ctrl`

## Requirements
- R1: The control byte reads back as the value last written, with this bit layout: [0] receive enable, [1] transmit enable, [2] reserved and always read as 0, [4:3] host flags, [6:5] mode, [7] init.
- R2: After reset the control byte reads 0x00, which is interrupt mode. The transfer flags read 4'b0110, the counter reads 0 and `cfg_illegal` is low.
- R3: A write with bit 7 set reads back with bit 7 high for exactly one cycle. The init command runs on the following clock edge, and from then on bit 7 reads 0.
- R4: Init with both request enables low leaves all four transfer flags unchanged.
- R5: Init with the receive enable set, unless the combination is illegal, clears flag 0 (core-side receive full) and sets flag 1 (host-side transmit empty).
- R6: Init with the transmit enable set, unless the combination is illegal, sets flag 2 (core-side transmit empty) and clears flag 3 (host-side receive full).
- R7: In interrupt mode (00), init with both enables set applies the R5 and R6 changes together.
- R8: Init loads the counter with the mode value. Mode 00 gives 0, mode 01 (24-bit DMA) gives 1, mode 10 (16-bit DMA) gives 2 and mode 11 (8-bit DMA) gives 3.
- R9: `cfg_illegal` is high while the mode is not 00 and both enables are set. An init in that state changes no transfer flag.
- R10: Each `dp_byte_step` pulse raises the counter by 1. From 3 the counter wraps to the value that init would load for the current mode.
- R11: `dp_flag_set` and `dp_flag_clr` act bit by bit on the flags. Set wins when both are high. Both strobes are ignored in the cycle in which init runs.
- R12: `xfer_mode` and `host_flags` mirror control bits [6:5] and [4:3].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_wr | input | 1 | Host write strobe for the control byte |
| host_wdata | input | 8 | Control byte written by the host |
| host_rdata | output | 8 | Current control byte |
| dp_flag_set | input | 4 | Data-path strobes that set transfer flags |
| dp_flag_clr | input | 4 | Data-path strobes that clear transfer flags |
| dp_byte_step | input | 1 | Data-path byte access; advances the counter |
| xfer_flags | output | 4 | Transfer flags [3:0] as listed in R5 and R6 |
| byte_cnt | output | 2 | Byte address counter |
| xfer_mode | output | 2 | Mode field |
| host_flags | output | 2 | Host flag bits |
| cfg_illegal | output | 1 | Illegal mode and enable combination |

## Verification
A host write shows in `host_rdata`, `xfer_mode`, `host_flags` and `cfg_illegal` one clock edge after the write. The init effects on the flags and the counter show one edge later. Data-path strobes and counter steps take effect on the edge where they are sampled. The bench drives every input on the falling edge. It samples the readback one falling edge after the write strobe and the init results two falling edges after it. This keeps each check in the first stable half-cycle after the register that produces the result.

// File: rtl/hport_pkg.sv
package hport_pkg;

   typedef enum logic [1:0] {
      MODE_IRQ   = 2'd0,
      MODE_DMA24 = 2'd1,
      MODE_DMA16 = 2'd2,
      MODE_DMA8  = 2'd3
   } hmode_e;

   typedef struct packed {
      logic        init;
      hmode_e      mode;
      logic [1:0]  hf;
      logic        rsvd;
      logic        tx_en;
      logic        rx_en;
   } icr_t;

   localparam int ICR_W         = $bits(icr_t);
   localparam int FLG_DRX_FULL  = 0;
   localparam int FLG_HTX_EMPTY = 1;
   localparam int FLG_DTX_EMPTY = 2;
   localparam int FLG_HRX_FULL  = 3;
   localparam int FLG_COUNT     = 4;

endpackage

// File: rtl/hport_icr.sv
module hport_icr
   import hport_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [DATA_W-1:0] wdata,
   output icr_t              icr,
   output logic              exec
);

   icr_t icr_q;
   icr_t wr_val;

   always_comb begin
      wr_val      = icr_t'(wdata);
      wr_val.rsvd = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         icr_q <= '0;
      end else if (wr) begin
         icr_q <= wr_val;
      end else if (icr_q.init) begin
         icr_q.init <= 1'b0;
      end
   end

   assign icr  = icr_q;
   assign exec = icr_q.init;

endmodule

// File: rtl/hport_init_decode.sv
module hport_init_decode
   import hport_pkg::*;
#(
   parameter int NUM_FLAGS   = 4,
   parameter int CNT_W       = 2,
   parameter bit DMA_PRELOAD = 1'b1
) (
   input  icr_t                 icr,
   output logic [NUM_FLAGS-1:0] set_mask,
   output logic [NUM_FLAGS-1:0] clr_mask,
   output logic [CNT_W-1:0]     cnt_base,
   output logic                 illegal
);

   logic dma_on;
   logic apply_rx;
   logic apply_tx;

   assign dma_on   = (icr.mode != MODE_IRQ);
   assign illegal  = dma_on & icr.rx_en & icr.tx_en;
   assign apply_rx = icr.rx_en & ~illegal;
   assign apply_tx = icr.tx_en & ~illegal;

   always_comb begin
      set_mask = '0;
      clr_mask = '0;
      clr_mask[FLG_DRX_FULL]  = apply_rx;
      set_mask[FLG_HTX_EMPTY] = apply_rx;
      set_mask[FLG_DTX_EMPTY] = apply_tx;
      clr_mask[FLG_HRX_FULL]  = apply_tx;
   end

   generate
      if (DMA_PRELOAD) begin : g_mode_base
         assign cnt_base = CNT_W'(icr.mode);
      end else begin : g_zero_base
         assign cnt_base = '0;
      end
   endgenerate

endmodule

// File: rtl/hport_flags.sv
module hport_flags #(
   parameter int                   NUM_FLAGS = 4,
   parameter logic [NUM_FLAGS-1:0] RST_VAL   = '0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 exec,
   input  logic [NUM_FLAGS-1:0] init_set,
   input  logic [NUM_FLAGS-1:0] init_clr,
   input  logic [NUM_FLAGS-1:0] dp_set,
   input  logic [NUM_FLAGS-1:0] dp_clr,
   output logic [NUM_FLAGS-1:0] flags
);

   generate
      for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               flags[i] <= RST_VAL[i];
            end else if (exec) begin
               if (init_set[i]) begin
                  flags[i] <= 1'b1;
               end else if (init_clr[i]) begin
                  flags[i] <= 1'b0;
               end
            end else if (dp_set[i]) begin
               flags[i] <= 1'b1;
            end else if (dp_clr[i]) begin
               flags[i] <= 1'b0;
            end
         end
      end
   endgenerate

endmodule

// File: rtl/hport_addr_cnt.sv
module hport_addr_cnt #(
   parameter int CNT_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] base,
   input  logic             step,
   output logic [CNT_W-1:0] cnt
);

   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (load) begin
         cnt <= base;
      end else if (step) begin
         cnt <= (cnt == CNT_MAX) ? base : cnt + 1'b1;
      end
   end

endmodule

// File: rtl/hport_ctrl.sv
module hport_ctrl
   import hport_pkg::*;
#(
   parameter int                   DATA_W      = 8,
   parameter int                   CNT_W       = 2,
   parameter int                   NUM_FLAGS   = 4,
   parameter logic [NUM_FLAGS-1:0] FLAG_RST    = 4'b0110,
   parameter bit                   DMA_PRELOAD = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 host_wr,
   input  logic [DATA_W-1:0]    host_wdata,
   output logic [DATA_W-1:0]    host_rdata,
   input  logic [NUM_FLAGS-1:0] dp_flag_set,
   input  logic [NUM_FLAGS-1:0] dp_flag_clr,
   input  logic                 dp_byte_step,
   output logic [NUM_FLAGS-1:0] xfer_flags,
   output logic [CNT_W-1:0]     byte_cnt,
   output logic [1:0]           xfer_mode,
   output logic [1:0]           host_flags,
   output logic                 cfg_illegal
);

   generate
      if (DATA_W != ICR_W) begin : g_bad_data_w
         $error("hport_ctrl: DATA_W must equal the control byte width");
      end
      if (CNT_W != 2) begin : g_bad_cnt_w
         $error("hport_ctrl: CNT_W must be 2 to hold every mode value");
      end
      if (NUM_FLAGS != FLG_COUNT) begin : g_bad_flags
         $error("hport_ctrl: NUM_FLAGS must match the transfer flag set");
      end
   endgenerate

   icr_t                 icr;
   logic                 exec;
   logic [NUM_FLAGS-1:0] init_set;
   logic [NUM_FLAGS-1:0] init_clr;
   logic [CNT_W-1:0]     cnt_base;

   hport_icr #(.DATA_W(DATA_W)) u_icr (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (host_wr),
      .wdata (host_wdata),
      .icr   (icr),
      .exec  (exec)
   );

   hport_init_decode #(
      .NUM_FLAGS   (NUM_FLAGS),
      .CNT_W       (CNT_W),
      .DMA_PRELOAD (DMA_PRELOAD)
   ) u_dec (
      .icr      (icr),
      .set_mask (init_set),
      .clr_mask (init_clr),
      .cnt_base (cnt_base),
      .illegal  (cfg_illegal)
   );

   hport_flags #(.NUM_FLAGS(NUM_FLAGS), .RST_VAL(FLAG_RST)) u_flags (
      .clk      (clk),
      .rst_n    (rst_n),
      .exec     (exec),
      .init_set (init_set),
      .init_clr (init_clr),
      .dp_set   (dp_flag_set),
      .dp_clr   (dp_flag_clr),
      .flags    (xfer_flags)
   );

   hport_addr_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (exec),
      .base  (cnt_base),
      .step  (dp_byte_step),
      .cnt   (byte_cnt)
   );

   assign host_rdata = DATA_W'(icr);
   assign xfer_mode  = icr.mode;
   assign host_flags = icr.hf;

endmodule

// File: rtl/hport_ctrl_chk.sv
module hport_ctrl_chk #(
   parameter int DATA_W    = 8,
   parameter int CNT_W     = 2,
   parameter int NUM_FLAGS = 4
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 host_wr,
   input logic [DATA_W-1:0]    host_rdata,
   input logic                 dp_byte_step,
   input logic [NUM_FLAGS-1:0] xfer_flags,
   input logic [CNT_W-1:0]     byte_cnt,
   input logic                 cfg_illegal
);

   assert_init_selfclear_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (host_rdata[7] && !host_wr) |=> !host_rdata[7]);

   assert_idle_init_keeps_flags_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (host_rdata[7] && host_rdata[1:0] == 2'b00) |=> $stable(xfer_flags));

   assert_rx_init_flags_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (host_rdata[7] && host_rdata[0] && !cfg_illegal) |=> (!xfer_flags[0] && xfer_flags[1]));

   assert_tx_init_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (host_rdata[7] && host_rdata[1] && !cfg_illegal) |=> (xfer_flags[2] && !xfer_flags[3]));

   assert_init_cnt_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
      host_rdata[7] |=> (byte_cnt == $past(host_rdata[6:5])));

   assert_illegal_keeps_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (host_rdata[7] && cfg_illegal) |=> $stable(xfer_flags));

   assert_cnt_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!host_rdata[7] && dp_byte_step && byte_cnt != '1) |=> (byte_cnt == $past(byte_cnt) + 1'b1));

endmodule

bind hport_ctrl hport_ctrl_chk #(
   .DATA_W    (DATA_W),
   .CNT_W     (CNT_W),
   .NUM_FLAGS (NUM_FLAGS)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .host_wr      (host_wr),
   .host_rdata   (host_rdata),
   .dp_byte_step (dp_byte_step),
   .xfer_flags   (xfer_flags),
   .byte_cnt     (byte_cnt),
   .cfg_illegal  (cfg_illegal)
);

// File: tb/hport_ctrl_bench.sv
`timescale 1ns/1ps
module hport_ctrl_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       host_wr = 1'b0;
   logic [7:0] host_wdata = '0;
   logic [7:0] host_rdata;
   logic [3:0] dp_flag_set = '0;
   logic [3:0] dp_flag_clr = '0;
   logic       dp_byte_step = 1'b0;
   logic [3:0] xfer_flags;
   logic [1:0] byte_cnt;
   logic [1:0] xfer_mode;
   logic [1:0] host_flags;
   logic       cfg_illegal;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   hport_ctrl u_hport_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .host_wr      (host_wr),
      .host_wdata   (host_wdata),
      .host_rdata   (host_rdata),
      .dp_flag_set  (dp_flag_set),
      .dp_flag_clr  (dp_flag_clr),
      .dp_byte_step (dp_byte_step),
      .xfer_flags   (xfer_flags),
      .byte_cnt     (byte_cnt),
      .xfer_mode    (xfer_mode),
      .host_flags   (host_flags),
      .cfg_illegal  (cfg_illegal)
   );

   // {mode, enables {tx,rx}, preset flags, expected flags, expected counter, expected illegal}
   localparam logic [14:0] VEC [16] = '{
      {2'd0, 2'b00, 4'b1001, 4'b1001, 2'd0, 1'b0},
      {2'd0, 2'b01, 4'b1001, 4'b1010, 2'd0, 1'b0},
      {2'd0, 2'b10, 4'b1001, 4'b0101, 2'd0, 1'b0},
      {2'd0, 2'b11, 4'b1001, 4'b0110, 2'd0, 1'b0},
      {2'd1, 2'b00, 4'b1001, 4'b1001, 2'd1, 1'b0},
      {2'd1, 2'b01, 4'b1001, 4'b1010, 2'd1, 1'b0},
      {2'd1, 2'b10, 4'b1001, 4'b0101, 2'd1, 1'b0},
      {2'd1, 2'b11, 4'b1001, 4'b1001, 2'd1, 1'b1},
      {2'd2, 2'b00, 4'b1001, 4'b1001, 2'd2, 1'b0},
      {2'd2, 2'b01, 4'b1001, 4'b1010, 2'd2, 1'b0},
      {2'd2, 2'b10, 4'b1001, 4'b0101, 2'd2, 1'b0},
      {2'd2, 2'b11, 4'b1001, 4'b1001, 2'd2, 1'b1},
      {2'd3, 2'b00, 4'b1001, 4'b1001, 2'd3, 1'b0},
      {2'd3, 2'b01, 4'b1001, 4'b1010, 2'd3, 1'b0},
      {2'd3, 2'b10, 4'b1001, 4'b0101, 2'd3, 1'b0},
      {2'd3, 2'b11, 4'b1001, 4'b1001, 2'd3, 1'b1}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic report();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   task automatic preset(input logic [3:0] val);
      @(negedge clk);
      dp_flag_clr = 4'hF;
      dp_flag_set = val;
      @(negedge clk);
      dp_flag_clr = '0;
      dp_flag_set = '0;
   endtask

   task automatic host_write(input logic [7:0] val);
      @(negedge clk);
      host_wr    = 1'b1;
      host_wdata = val;
      @(negedge clk);
      host_wr    = 1'b0;
   endtask

   task automatic step_chk(input logic [1:0] exp);
      @(negedge clk);
      dp_byte_step = 1'b1;
      @(negedge clk);
      dp_byte_step = 1'b0;
      chk("R10 counter step", 32'(byte_cnt), 32'(exp));
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      report();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R2 reset state
      chk("R2 reset rdata", 32'(host_rdata), 32'h00);
      chk("R2 reset flags", 32'(xfer_flags), 32'h6);
      chk("R2 reset counter", 32'(byte_cnt), 32'd0);
      chk("R2 reset illegal", 32'(cfg_illegal), 32'd0);

      // table walk over every mode and enable combination
      for (int i = 0; i < 16; i++) begin
         logic [1:0] md;
         logic [1:0] en;
         logic [1:0] hf;
         logic [7:0] wv;
         md = VEC[i][14:13];
         en = VEC[i][12:11];
         hf = 2'(i);
         preset(VEC[i][10:7]);
         wv = {1'b1, md, hf, 1'b0, en};
         host_write(wv);
         chk("R3 init visible one cycle", 32'(host_rdata[7]), 32'd1);
         chk("R9 illegal level", 32'(cfg_illegal), 32'(VEC[i][0]));
         @(negedge clk);
         chk("R3 init cleared", 32'(host_rdata[7]), 32'd0);
         chk("R4/R5/R6/R7/R9 flags after init", 32'(xfer_flags), 32'(VEC[i][6:3]));
         chk("R8 counter after init", 32'(byte_cnt), 32'(VEC[i][2:1]));
         chk("R1 readback", 32'(host_rdata), 32'({1'b0, md, hf, 1'b0, en}));
         chk("R12 mode mirror", 32'(xfer_mode), 32'(md));
         chk("R12 host flag mirror", 32'(host_flags), 32'(hf));
      end

      // R1 reserved bit reads 0
      host_write(8'h04);
      chk("R1 reserved bit", 32'(host_rdata), 32'h00);

      // R11 set wins over clear, then plain clear
      preset(4'b0101);
      chk("R11 set wins", 32'(xfer_flags), 32'h5);
      @(negedge clk);
      dp_flag_clr = 4'b0011;
      @(negedge clk);
      dp_flag_clr = '0;
      chk("R11 clear", 32'(xfer_flags), 32'h4);

      // R11 strobes ignored in the init cycle
      @(negedge clk);
      host_wr    = 1'b1;
      host_wdata = 8'h80;
      @(negedge clk);
      host_wr     = 1'b0;
      dp_flag_set = 4'hF;
      @(negedge clk);
      dp_flag_set = '0;
      chk("R11 ignored during init", 32'(xfer_flags), 32'h4);
      chk("R8 interrupt mode counter", 32'(byte_cnt), 32'd0);

      // R10 interrupt mode wraps to 0
      step_chk(2'd1);
      step_chk(2'd2);
      step_chk(2'd3);
      step_chk(2'd0);

      // R10 24-bit DMA wraps to 1
      host_write(8'hA0);
      @(negedge clk);
      chk("R8 dma24 counter", 32'(byte_cnt), 32'd1);
      step_chk(2'd2);
      step_chk(2'd3);
      step_chk(2'd1);

      // R10 16-bit DMA wraps to 2
      host_write(8'hC0);
      @(negedge clk);
      chk("R8 dma16 counter", 32'(byte_cnt), 32'd2);
      step_chk(2'd3);
      step_chk(2'd2);

      // R10 8-bit DMA stays at 3
      host_write(8'hE0);
      @(negedge clk);
      chk("R8 dma8 counter", 32'(byte_cnt), 32'd3);
      step_chk(2'd3);

      // R3 write without init leaves flags and counter alone
      host_write(8'h18);
      @(negedge clk);
      chk("R3 no init readback", 32'(host_rdata), 32'h18);
      chk("R3 no init flags", 32'(xfer_flags), 32'h4);
      chk("R3 no init counter", 32'(byte_cnt), 32'd3);

      report();
   end

endmodule